// File: doc/BRIEF.md
# Nibble Accumulator Datapath with Carry

This block is the arithmetic core of a small 4-bit controller. It holds a 4-bit accumulator, a carry flag, a 4-bit auxiliary register and an 8-bit extension register. Each cycle it may receive one already-decoded operation code, together with a 4-bit immediate and a 4-bit memory operand. When the valid strobe is high, the operation runs in that clock. The operations cover three add forms, rotate right through carry, carry set and clear, bitwise AND and OR, an equality compare, and register transfers. The 8-bit register is split into two nibbles: its high nibble pairs with the auxiliary register and its low nibble pairs with the accumulator.

Every state element and the compare-skip output are registered. Results are visible just after the clock edge at which the strobe was sampled high. Instruction fetch, the program counter, RAM addressing and I/O are not part of this block. They sit around it in the controller.

Top module: `acc_nibble_dp`

## Requirements
- R1: While reset is high, and on the first clock after it, the accumulator, the auxiliary register, the carry and the skip output are all 0. The extension register is not reset.
- R2: Operation code 1 (add with carry) loads the low 4 bits of accumulator + memory operand + carry into the accumulator. It sets the carry to 1 exactly when that sum exceeds 15 and clears it otherwise.
- R3: Operation code 2 (add immediate) writes the low 4 bits of accumulator + immediate, and operation code 3 (add memory) writes the low 4 bits of accumulator + memory operand. Neither changes the carry.
- R4: Operation code 4 (rotate right) loads {carry, A[3:1]} into the accumulator and the old A[0] into the carry.
- R5: Operation code 5 sets the carry to 1 and operation code 6 clears it to 0. The accumulator is unchanged.
- R6: Operation code 7 writes accumulator AND memory operand into the accumulator, and operation code 8 writes accumulator OR memory operand. The carry is unchanged.
- R7: Operation code 9 (compare) drives the skip output high for exactly the one cycle after the operation when the accumulator equals the memory operand. Otherwise skip stays low. Compare leaves the accumulator and the carry unchanged.
- R8: Operation code 10 copies the accumulator into the auxiliary register, and operation code 11 copies the auxiliary register into the accumulator.
- R9: Operation code 12 loads the auxiliary register from E[7:4] and the accumulator from E[3:0]. Operation code 13 loads E from {auxiliary, accumulator}.
- R10: With the strobe low, or with operation codes 0, 14 or 15, no register changes and skip is low on the next cycle.
- R11: Each operation's result appears on the outputs right after the clock edge at which its strobe was sampled high. Back-to-back operations on consecutive cycles each take effect in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Decoded operation code |
| imm | input | 4 | Immediate operand |
| mem | input | 4 | Memory operand |
| acc_o | output | 4 | Accumulator |
| aux_o | output | 4 | Auxiliary register |
| ext_o | output | 8 | Extension register |
| carry_o | output | 1 | Carry flag |
| skip_o | output | 1 | Compare-equal skip pulse |

## Verification
The skip pulse left by a compare is still high in the cycle in which the next operation is already being applied. A compare followed at once by an add, or by a second compare, therefore makes the skip output and a new accumulator update fall in the same cycle. The bench issues compare-then-add with no gap. It then expects skip high while the add is sampled, the sum on the following cycle, and skip low again. It also issues two compares in a row, one equal and one not equal, and expects a high pulse followed directly by a low one.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_NOP  = 4'd0,
    OP_ADC  = 4'd1,
    OP_ADDI = 4'd2,
    OP_ADDM = 4'd3,
    OP_RAR  = 4'd4,
    OP_SETC = 4'd5,
    OP_CLRC = 4'd6,
    OP_AND  = 4'd7,
    OP_OR   = 4'd8,
    OP_CMP  = 4'd9,
    OP_A2B  = 4'd10,
    OP_B2A  = 4'd11,
    OP_E2AB = 4'd12,
    OP_AB2E = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } op_e;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DW = 4,
  localparam int EW = 2 * DW
) (
  input  logic          valid,
  input  logic [OPW-1:0] code,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [EW-1:0] e,
  input  logic          cy,
  input  logic [DW-1:0] n,
  input  logic [DW-1:0] m,
  output logic [DW-1:0] nxt_a,
  output logic [DW-1:0] nxt_b,
  output logic [EW-1:0] nxt_e,
  output logic          nxt_cy,
  output logic          we_a,
  output logic          we_b,
  output logic          we_e,
  output logic          we_cy,
  output logic          hit
);
  op_e            op;
  logic [DW:0]    sum_c;
  logic [DW:0]    sum_i;
  logic [DW:0]    sum_m;

  assign op    = op_e'(code);
  assign sum_c = {1'b0, a} + {1'b0, m} + {{DW{1'b0}}, cy};
  assign sum_i = {1'b0, a} + {1'b0, n};
  assign sum_m = {1'b0, a} + {1'b0, m};

  always_comb begin
    nxt_a  = a;
    nxt_b  = b;
    nxt_e  = e;
    nxt_cy = cy;
    we_a   = 1'b0;
    we_b   = 1'b0;
    we_e   = 1'b0;
    we_cy  = 1'b0;
    hit    = 1'b0;
    if (valid) begin
      unique case (op)
        OP_ADC: begin
          nxt_a = sum_c[DW-1:0]; nxt_cy = sum_c[DW];
          we_a = 1'b1; we_cy = 1'b1;
        end
        OP_ADDI: begin nxt_a = sum_i[DW-1:0]; we_a = 1'b1; end
        OP_ADDM: begin nxt_a = sum_m[DW-1:0]; we_a = 1'b1; end
        OP_RAR: begin
          nxt_a = {cy, a[DW-1:1]}; nxt_cy = a[0];
          we_a = 1'b1; we_cy = 1'b1;
        end
        OP_SETC: begin nxt_cy = 1'b1; we_cy = 1'b1; end
        OP_CLRC: begin nxt_cy = 1'b0; we_cy = 1'b1; end
        OP_AND:  begin nxt_a = a & m; we_a = 1'b1; end
        OP_OR:   begin nxt_a = a | m; we_a = 1'b1; end
        OP_CMP:  hit = (a == m);
        OP_A2B:  begin nxt_b = a; we_b = 1'b1; end
        OP_B2A:  begin nxt_a = b; we_a = 1'b1; end
        OP_E2AB: begin
          nxt_b = e[EW-1:DW]; nxt_a = e[DW-1:0];
          we_a = 1'b1; we_b = 1'b1;
        end
        OP_AB2E: begin nxt_e = {b, a}; we_e = 1'b1; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acc_regs.sv
module acc_regs #(
  parameter int DW = 4,
  localparam int EW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] nxt_a,
  input  logic [DW-1:0] nxt_b,
  input  logic [EW-1:0] nxt_e,
  input  logic          nxt_cy,
  input  logic          we_a,
  input  logic          we_b,
  input  logic          we_e,
  input  logic          we_cy,
  input  logic          hit,
  output logic [DW-1:0] a_q,
  output logic [DW-1:0] b_q,
  output logic [EW-1:0] e_q,
  output logic          cy_q,
  output logic          skip_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      cy_q   <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      if (we_a)  a_q  <= nxt_a;
      if (we_b)  b_q  <= nxt_b;
      if (we_cy) cy_q <= nxt_cy;
      skip_q <= hit;
    end
  end

  // Extension register carries no reset; software initialises it.
  always_ff @(posedge clk) begin
    if (we_e && !rst) e_q <= nxt_e;
  end

  AST_SKIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    skip_q |=> !skip_q || $past(hit)); // R7
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(we_a || we_b || we_cy || we_e) |=> $stable(a_q) && $stable(b_q) && $stable(cy_q) && $stable(e_q)); // R10
endmodule

// File: rtl/acc_nibble_dp.sv
module acc_nibble_dp
  import acc_pkg::*;
#(
  parameter int DW = 4,
  localparam int EW = 2 * DW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  input  logic [DW-1:0]  imm,
  input  logic [DW-1:0]  mem,
  output logic [DW-1:0]  acc_o,
  output logic [DW-1:0]  aux_o,
  output logic [EW-1:0]  ext_o,
  output logic           carry_o,
  output logic           skip_o
);
  logic [DW-1:0] nxt_a, nxt_b;
  logic [EW-1:0] nxt_e;
  logic          nxt_cy, we_a, we_b, we_e, we_cy, hit;

  acc_alu #(.DW(DW)) u_alu (
    .valid(op_valid), .code(op_code), .a(acc_o), .b(aux_o), .e(ext_o),
    .cy(carry_o), .n(imm), .m(mem),
    .nxt_a(nxt_a), .nxt_b(nxt_b), .nxt_e(nxt_e), .nxt_cy(nxt_cy),
    .we_a(we_a), .we_b(we_b), .we_e(we_e), .we_cy(we_cy), .hit(hit)
  );

  acc_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst),
    .nxt_a(nxt_a), .nxt_b(nxt_b), .nxt_e(nxt_e), .nxt_cy(nxt_cy),
    .we_a(we_a), .we_b(we_b), .we_e(we_e), .we_cy(we_cy), .hit(hit),
    .a_q(acc_o), .b_q(aux_o), .e_q(ext_o), .cy_q(carry_o), .skip_q(skip_o)
  );

  logic is_keepcy, is_cmp;
  assign is_keepcy = op_valid && (op_code == OP_ADDI || op_code == OP_ADDM ||
                     op_code == OP_AND || op_code == OP_OR || op_code == OP_CMP);
  assign is_cmp = op_valid && op_code == OP_CMP;

  AST_ADD_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
    is_keepcy |=> $stable(carry_o)); // R3
  AST_SET_CARRY: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_SETC) |=> carry_o); // R5
  AST_CLR_CARRY: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_CLRC) |=> !carry_o); // R5
  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    is_cmp |=> $stable(acc_o) && $stable(carry_o)); // R7
  AST_SKIP_NEEDS_CMP: assert property (@(posedge clk) disable iff (rst)
    !is_cmp |=> !skip_o); // R7
  AST_ROTATE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_RAR) |=> carry_o == $past(acc_o[0])); // R4
  AST_A_TO_B: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_A2B) |=> aux_o == $past(acc_o)); // R8
endmodule

// File: tb/test_acc_nibble_dp.sv
module test_acc_nibble_dp;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [3:0] imm = 4'd0;
  logic [3:0] mem = 4'd0;
  logic [3:0] acc_o, aux_o;
  logic [7:0] ext_o;
  logic       carry_o, skip_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  acc_nibble_dp i_acc_nibble_dp (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .imm(imm), .mem(mem), .acc_o(acc_o), .aux_o(aux_o), .ext_o(ext_o),
    .carry_o(carry_o), .skip_o(skip_o)
  );

  // Model state
  logic [3:0] ma, mb;
  logic [7:0] me;
  logic       mc;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " acc"}, acc_o, ma);
    chk({tag, " aux"}, aux_o, mb);
    chk({tag, " carry"}, carry_o, mc);
  endtask

  // Issue one op at a negedge, return at the next negedge with valid low.
  task automatic do_op(input logic [3:0] c, input logic [3:0] n, input logic [3:0] m);
    op_valid = 1'b1; op_code = c; imm = n; mem = m;
    @(negedge clk);
    op_valid = 1'b0; op_code = 4'd0;
  endtask

  task automatic t_reset();
    chk("R1 acc", acc_o, 0); chk("R1 aux", aux_o, 0);
    chk("R1 carry", carry_o, 0); chk("R1 skip", skip_o, 0);
    ma = 0; mb = 0; mc = 0;
  endtask

  task automatic t_ext_init();
    do_op(4'd13, 0, 0); me = 8'h00;          // R9 AB2E from zeros
    chk("R9 ext init", ext_o, me);
  endtask

  task automatic t_adc();
    logic [4:0] s;
    do_op(4'd2, 4'd9, 0); ma = 4'd9;
    s = ma + 5'd9 + mc; do_op(4'd1, 0, 4'd9); ma = s[3:0]; mc = s[4];
    chk_state("R2 adc carry out");
    s = ma + 5'd3 + mc; do_op(4'd1, 0, 4'd3); ma = s[3:0]; mc = s[4];
    chk_state("R2 adc with carry in");
    s = ma + 5'd15 + mc; do_op(4'd1, 0, 4'd15); ma = s[3:0]; mc = s[4];
    chk_state("R2 adc boundary");
  endtask

  task automatic t_add_keep();
    do_op(4'd5, 0, 0); mc = 1;
    do_op(4'd2, 4'd15, 0); ma = ma + 4'd15;
    chk_state("R3 addi keeps carry set");
    do_op(4'd6, 0, 0); mc = 0;
    do_op(4'd3, 0, 4'd14); ma = ma + 4'd14;
    chk_state("R3 addm overflow keeps carry clear");
  endtask

  task automatic t_rar();
    do_op(4'd11, 0, 0); ma = mb;               // reuse B2A
    do_op(4'd2, 4'd5, 0); ma = ma + 4'd5;
    do_op(4'd5, 0, 0); mc = 1;
    chk_state("R5 setc");
    for (int i = 0; i < 5; i++) begin
      logic c0;
      c0 = ma[0];
      do_op(4'd4, 0, 0); ma = {mc, ma[3:1]}; mc = c0;
      chk_state("R4 rar");
    end
    do_op(4'd6, 0, 0); mc = 0;
    chk_state("R5 clrc");
  endtask

  task automatic t_logic();
    do_op(4'd5, 0, 0); mc = 1;
    do_op(4'd8, 0, 4'b1010); ma = ma | 4'b1010;
    chk_state("R6 or");
    do_op(4'd7, 0, 4'b0110); ma = ma & 4'b0110;
    chk_state("R6 and");
  endtask

  task automatic t_transfer();
    do_op(4'd2, 4'd7, 0); ma = ma + 4'd7;
    do_op(4'd10, 0, 0); mb = ma;
    chk_state("R8 a2b");
    do_op(4'd3, 0, 4'd4); ma = ma + 4'd4;
    do_op(4'd13, 0, 0); me = {mb, ma};
    chk("R9 ab2e", ext_o, me);
    do_op(4'd2, 4'd1, 0); ma = ma + 4'd1;
    do_op(4'd11, 0, 0); ma = mb;
    chk_state("R8 b2a");
    do_op(4'd10, 0, 0); mb = ma;
    do_op(4'd12, 0, 0); mb = me[7:4]; ma = me[3:0];
    chk_state("R9 e2ab");
  endtask

  task automatic t_idle();
    logic [3:0] sa;
    sa = ma;
    op_valid = 1'b0; op_code = 4'd1; mem = 4'd15;
    @(negedge clk);
    chk_state("R10 valid low");
    chk("R10 skip low", skip_o, 0);
    do_op(4'd0, 4'd3, sa); chk_state("R10 nop");
    chk("R10 nop skip", skip_o, 0);
    do_op(4'd14, 4'd3, 4'd3); chk_state("R10 code14");
    do_op(4'd15, 4'd3, 4'd3); chk_state("R10 code15");
    chk("R10 ext held", ext_o, me);
  endtask

  task automatic t_cmp_overlap();
    // compare equal then add immediately
    op_valid = 1'b1; op_code = 4'd9; mem = ma;
    @(negedge clk);
    chk("R7 skip after equal", skip_o, 1);
    chk_state("R7 cmp keeps state");
    op_code = 4'd2; imm = 4'd6;
    @(negedge clk);
    ma = ma + 4'd6;
    chk("R11 skip drops", skip_o, 0);
    chk_state("R11 add after cmp");
    // two compares back to back: equal then not equal
    op_code = 4'd9; mem = ma;
    @(negedge clk);
    chk("R7 first cmp equal", skip_o, 1);
    mem = ma + 4'd1;
    @(negedge clk);
    chk("R7 second cmp unequal", skip_o, 0);
    op_valid = 1'b0;
    @(negedge clk);
    chk("R7 skip idle", skip_o, 0);
  endtask

  task automatic t_b2b();
    // R11 consecutive ops with no gap
    op_valid = 1'b1; op_code = 4'd2; imm = 4'd3;
    @(negedge clk); ma = ma + 4'd3; chk_state("R11 b2b first");
    op_code = 4'd10;
    @(negedge clk); mb = ma; chk_state("R11 b2b second");
    op_code = 4'd5;
    @(negedge clk); mc = 1; chk_state("R11 b2b third");
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ext_init();
    t_adc();
    t_add_keep();
    t_rar();
    t_logic();
    t_transfer();
    t_idle();
    t_cmp_overlap();
    t_b2b();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule